// File: doc/BRIEF.md
# Debug Message Sequence Tracker

This block follows a fixed, ordered set of debug message arrivals, labelled A, B and C. Each arrival shows up as a one-cycle pulse on its own bit of a message vector. The tracker advances one step for each pulse that matches the message it expects next. Any other pulse is ignored.

After the last message of the sequence arrives, the block raises a DMA request level so that a DMA engine can fetch the collected messages. The request stays high until the engine pulses its completion input. That pulse returns the tracker to idle and drops the request. The progress code is a plain binary count of the messages collected so far, and software can read it.

The sequence length is a parameter, `NUM_MSGS`, with a default of 3. Bit k of the message vector is the k-th message of the order: bit 0 is A, bit 1 is B and bit 2 is C. Reset is synchronous and active high.

Top module: `dbg_seq_tracker`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the next state is `stage_o` = 0 and `dma_req_o` = 0, whatever the other inputs are.
- R2: In stage 0, a pulse on `msg_i[0]` (message A) moves `stage_o` to 1 at that clock edge.
- R3: In stage 1, a pulse on `msg_i[1]` (message B) moves `stage_o` to 2 at that clock edge.
- R4: In stage 2, a pulse on `msg_i[2]` (message C) moves `stage_o` to 3 and sets `dma_req_o` high at the same edge.
- R5: Before stage 3 is reached, a pulse on any message bit other than the one at index `stage_o` leaves `stage_o` unchanged. Examples are B or C in stage 0, A or C in stage 1, and A or B in stage 2.
- R6: In stage 3, pulses on `msg_i` are ignored. While `dma_done_i` stays low, `stage_o` stays 3 and `dma_req_o` stays high.
- R7: In stage 3, a pulse on `dma_done_i` returns `stage_o` to 0 and drops `dma_req_o` at the next clock edge.
- R8: In stages 0 to 2, `dma_done_i` has no effect on `stage_o` or `dma_req_o`.
- R9: `dma_req_o` is high exactly when `stage_o` equals 3 (the full code).
- R10: When several message bits pulse in the same cycle, only the expected one counts. The stage advances by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| msg_i | input | NUM_MSGS | One-cycle arrival pulses; bit k is the k-th message of the order |
| dma_done_i | input | 1 | One-cycle DMA completion pulse |
| stage_o | output | clog2(NUM_MSGS+1) | Count of messages collected so far (0 means idle) |
| dma_req_o | output | 1 | DMA request level |

## Verification
A wrong internal stage reaches the ports at once, because `stage_o` is the state register itself. A skipped, repeated or missed step shows on the very next clock edge after the pulse that caused it. The request flop is a separate register. If it falls out of step with the stage, the mismatch between `dma_req_o` and the full code is visible in the same cycle. If the clear path is wrong, the request stays stuck high in a cycle where the stage has already returned to 0.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  // Stage update rule: a full tracker only leaves on completion,
  // otherwise an accepted message adds one.
  function automatic int unsigned step_stage(int unsigned cur, int unsigned full,
                                             logic adv, logic clr);
    if (cur == full) return clr ? 0 : full;
    return adv ? cur + 1 : cur;
  endfunction

  // True when the accepted message is the last of the order.
  function automatic logic is_last_step(int unsigned cur, int unsigned full, logic adv);
    return adv && (cur + 1 == full);
  endfunction

endpackage

// File: rtl/dbg_seq_qualify.sv
module dbg_seq_qualify #(
  parameter int NUM_MSGS = 3,
  localparam int STAGE_W = $clog2(NUM_MSGS + 1)
) (
  input  logic [STAGE_W-1:0]  stage_i,
  input  logic [NUM_MSGS-1:0] msg_i,
  input  logic                done_i,
  output logic                adv_o,
  output logic                clr_o
);
  localparam logic [STAGE_W-1:0] FULL = STAGE_W'(NUM_MSGS);

  logic [NUM_MSGS-1:0] hit;

  // Only the message whose index equals the current stage is accepted.
  for (genvar k = 0; k < NUM_MSGS; k++) begin : g_sel
    assign hit[k] = msg_i[k] && (stage_i == STAGE_W'(k));
  end

  assign adv_o = |hit;
  assign clr_o = done_i && (stage_i == FULL);
endmodule

// File: rtl/dbg_seq_stage_reg.sv
module dbg_seq_stage_reg
  import dbg_seq_pkg::*;
#(
  parameter int NUM_MSGS = 3,
  localparam int STAGE_W = $clog2(NUM_MSGS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               adv_i,
  input  logic               clr_i,
  output logic [STAGE_W-1:0] stage_o
);
  logic [STAGE_W-1:0] stage_q;
  logic [STAGE_W-1:0] stage_d;

  always_comb begin
    stage_d = STAGE_W'(step_stage(int'(stage_q), NUM_MSGS, adv_i, clr_i));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) stage_q <= '0;
    else       stage_q <= stage_d;
  end

  assign stage_o = stage_q;
endmodule

// File: rtl/dbg_seq_req_reg.sv
module dbg_seq_req_reg (
  input  logic clk_i,
  input  logic rst_i,
  input  logic set_i,
  input  logic clr_i,
  output logic req_o
);
  logic req_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)      req_q <= 1'b0;
    else if (clr_i) req_q <= 1'b0;
    else if (set_i) req_q <= 1'b1;
  end

  assign req_o = req_q;
endmodule

// File: rtl/dbg_seq_tracker.sv
module dbg_seq_tracker
  import dbg_seq_pkg::*;
#(
  parameter int NUM_MSGS = 3,
  localparam int STAGE_W = $clog2(NUM_MSGS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [NUM_MSGS-1:0] msg_i,
  input  logic                dma_done_i,
  output logic [STAGE_W-1:0]  stage_o,
  output logic                dma_req_o
);
  // Named internal events, visible to the bound checker.
  logic               adv_evt;
  logic               clr_evt;
  logic               fill_evt;
  logic [STAGE_W-1:0] stage_w;

  dbg_seq_qualify #(.NUM_MSGS(NUM_MSGS)) u_qual (
    .stage_i (stage_w),
    .msg_i   (msg_i),
    .done_i  (dma_done_i),
    .adv_o   (adv_evt),
    .clr_o   (clr_evt)
  );

  dbg_seq_stage_reg #(.NUM_MSGS(NUM_MSGS)) u_stage (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .adv_i   (adv_evt),
    .clr_i   (clr_evt),
    .stage_o (stage_w)
  );

  assign fill_evt = is_last_step(int'(stage_w), NUM_MSGS, adv_evt);

  dbg_seq_req_reg u_req (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .set_i (fill_evt),
    .clr_i (clr_evt),
    .req_o (dma_req_o)
  );

  assign stage_o = stage_w;
endmodule

// File: rtl/dbg_seq_chk.sv
module dbg_seq_chk #(
  parameter int NUM_MSGS = 3,
  localparam int STAGE_W = $clog2(NUM_MSGS + 1)
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic [NUM_MSGS-1:0] msg_i,
  input logic                done_i,
  input logic [STAGE_W-1:0]  stage_i,
  input logic                req_i
);
  localparam logic [STAGE_W-1:0] FULL = STAGE_W'(NUM_MSGS);
  localparam logic [STAGE_W-1:0] LAST = STAGE_W'(NUM_MSGS - 1);

  logic [NUM_MSGS-1:0] shifted;
  logic                exp_hit;
  assign shifted = msg_i >> stage_i;
  assign exp_hit = (stage_i != FULL) && shifted[0];

  p_reset_r1: assert property (@(posedge clk_i)
    rst_i |=> (stage_i == '0 && !req_i));

  // Covers R2 and R3 (and each earlier step of the order).
  p_advance_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    exp_hit |=> stage_i == STAGE_W'($past(stage_i) + 1'b1));

  p_fill_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (stage_i == LAST && msg_i[NUM_MSGS-1]) |=> (stage_i == FULL && req_i));

  // Also covers R8 (done outside full) and R10 (at most one step).
  p_ignore_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (stage_i != FULL && !exp_hit) |=> $stable(stage_i));

  p_hold_full_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (stage_i == FULL && !done_i) |=> (stage_i == FULL && req_i));

  p_clear_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (stage_i == FULL && done_i) |=> (stage_i == '0 && !req_i));

  p_req_match_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    req_i == (stage_i == FULL));
endmodule

bind dbg_seq_tracker dbg_seq_chk #(.NUM_MSGS(NUM_MSGS)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .msg_i   (msg_i),
  .done_i  (dma_done_i),
  .stage_i (stage_o),
  .req_i   (dma_req_o)
);

// File: tb/test_dbg_seq_tracker.sv
module test_dbg_seq_tracker;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] msg = '0;
  logic         done = 1'b0;
  logic [1:0]   stage;
  logic         req;

  int checks = 0;
  int errors = 0;
  int exp_st = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dbg_seq_tracker #(.NUM_MSGS(N)) i_dbg_seq_tracker (
    .clk_i(clk), .rst_i(rst), .msg_i(msg), .dma_done_i(done),
    .stage_o(stage), .dma_req_o(req)
  );

  // Expected next stage, written as an explicit state table.
  function automatic int model(int st, logic [2:0] m, logic d, logic r);
    if (r) return 0;
    case (st)
      0:       return m[0] ? 1 : 0;
      1:       return m[1] ? 2 : 1;
      2:       return m[2] ? 3 : 2;
      default: return d ? 0 : 3;
    endcase
  endfunction

  function automatic string classify(int st, logic [2:0] m, logic d, logic r);
    if (r)                 return "R1";
    if (st == 3)           return d ? "R7" : "R6";
    if (st == 2 && m[2])   return "R4";
    if (st == 1 && m[1])   return "R3";
    if (st == 0 && m[0])   return "R2";
    if (d)                 return "R8";
    if (m != 0)            return "R5";
    return "R9";
  endfunction

  task automatic check(string tag);
    logic exp_req;
    exp_req = (exp_st == 3);
    checks++;
    if (stage !== exp_st[1:0] || req !== exp_req) begin
      errors++;
      $display("FAIL %s: stage=%0d req=%0b expected stage=%0d req=%0b",
               tag, stage, req, exp_st, exp_req);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, check at the next falling edge.
  task automatic cyc(logic r, logic [2:0] m, logic d, string tag);
    rst = r; msg = m; done = d;
    @(posedge clk);
    exp_st = model(exp_st, m, d, r);
    @(negedge clk);
    rst = 1'b0; msg = '0; done = 1'b0;
    check(tag);
  endtask

  initial begin
    void'($urandom(32'd5113));
    @(negedge clk);
    cyc(1, 3'b000, 0, "R1");
    cyc(0, 3'b010, 0, "R5");   // B while idle
    cyc(0, 3'b100, 0, "R5");   // C while idle
    cyc(0, 3'b000, 1, "R8");   // done while idle
    cyc(0, 3'b001, 0, "R2");   // A
    cyc(0, 3'b001, 0, "R5");   // A again
    cyc(0, 3'b100, 0, "R5");   // C after only A
    cyc(0, 3'b000, 1, "R8");
    cyc(0, 3'b010, 0, "R3");   // B
    cyc(0, 3'b011, 0, "R5");   // A and B in stage 2
    cyc(0, 3'b100, 0, "R4");   // C: full, request set
    cyc(0, 3'b111, 0, "R6");
    cyc(0, 3'b000, 0, "R9");
    cyc(0, 3'b000, 1, "R7");
    cyc(0, 3'b111, 0, "R10");  // all bits: only A counts
    cyc(0, 3'b111, 0, "R10");
    cyc(0, 3'b111, 0, "R10");
    cyc(0, 3'b111, 1, "R7");   // done wins in full
    cyc(0, 3'b001, 0, "R2");
    cyc(0, 3'b010, 0, "R3");
    cyc(0, 3'b100, 0, "R4");
    cyc(1, 3'b000, 1, "R1");   // reset while full
    for (int i = 0; i < 4000; i++) begin
      logic       r;
      logic [2:0] m;
      logic       d;
      r = ($urandom % 100) == 0;
      m = {($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0};
      d = ($urandom % 4) == 0;
      cyc(r, m, d, classify(exp_st, m, d, r));
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: all requirements, run hung, actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule